// File: doc/BRIEF.md
# Opcode-Driven Transmit DMA Sequencer

This block moves a command table from memory into the register pair of a serial-protocol transmitter. The table is a run of opcode bytes. An opcode byte is followed by a data byte only when its 3-bit command code calls for one. When the transmitter signals that it is ready and the sequencer is enabled, the block reads the next opcode and strobes it into the transmitter's opcode register. If the decoded code carries a datum, it then reads the following byte and strobes it into the data register. Every accepted memory read advances an address pointer and decrements a transaction count.

Software loads a start address and a count with a start pulse and can stop the sequencer at any time. When the count runs out, the block raises an end-of-block flag and clears its own enable. It also raises a sticky underrun flag if the count ran out between an opcode that needs data and that data. An optional suspend mode holds back transfers while the protocol-error or lost-arbitration flag is active. A suspension that arrives between the opcode and its data keeps the cycle open and defers the data read.

Top module: `txdma_seq`

## Requirements
- R1: A start pulse loads the address pointer and the count. A nonzero count sets `dma_en` and clears `eob` and `underrun`. A zero count leaves `dma_en` at 0, sets `eob` on the next cycle, and no memory request follows.
- R2: A memory request for an opcode is raised only when `dma_en` and `tx_ready` are both 1 (and the suspend rule of R9 allows it). With `tx_ready` at 0, no request is made.
- R3: Every accepted read (`mem_req` and `mem_valid` in the same cycle) increments `mem_addr` by 1 and decrements the count by 1. The opcode comes from the current address and is presented on `wr_byte` with `op_wr` high.
- R4: The command code is bits [2:0] of the opcode byte. Codes 0 to 3 carry one data byte, read from the next address and presented with `data_wr` high. Codes 4 to 7 are opcode-only.
- R5: Within a cycle, `op_wr` always comes before `data_wr` and never in the same clock.
- R6: `ready_clr` pulses for one clock with the last write of each cycle, so one `tx_ready` request yields exactly one cycle.
- R7: When the count reaches zero after a write, `eob` becomes 1 and `dma_en` becomes 0. No further request follows.
- R8: If the count reaches zero on an opcode whose code needs data, no data read is made. In that case `eob` and a sticky `underrun` are set, and `ready_clr` pulses.
- R9: With `suspend_mode`=1, no new cycle starts while `proto_err` or `arb_lost` is 1. If the flag rises after the opcode write, the data request stays low until the flag clears, and then the cycle completes.
- R10: With `suspend_mode`=0, `proto_err` and `arb_lost` have no effect on transfers.
- R11: A `stop` pulse clears `dma_en`. No new cycle starts afterwards, `eob` is not set, and `tx_ready` stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load pointer and count, arm sequencer (accepted when idle) |
| start_addr | input | 16 | Table start address |
| start_count | input | 8 | Number of table bytes to move |
| stop | input | 1 | Software disable |
| suspend_mode | input | 1 | 1: hold transfers while error/arbitration flags are set |
| proto_err | input | 1 | Protocol error flag from transmitter |
| arb_lost | input | 1 | Lost-arbitration flag from transmitter |
| tx_ready | input | 1 | Transmitter requests next opcode |
| ready_clr | output | 1 | One-clock pulse clearing the ready flag at cycle end |
| mem_req | output | 1 | Memory read request, held until `mem_valid` |
| mem_addr | output | 16 | Read address (current pointer) |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| op_wr | output | 1 | Write strobe for the transmit opcode register |
| data_wr | output | 1 | Write strobe for the transmit data register |
| wr_byte | output | 8 | Byte to write with either strobe |
| dma_en | output | 1 | Sequencer enable |
| eob | output | 1 | End of block reached |
| underrun | output | 1 | Sticky: count ran out before a required data byte |

## Verification
The hardest case is a suspension that starts in the single clock between an opcode write and the data request, because the flag has to rise after the opcode strobe and before the next edge. The bench watches `op_wr` on the falling clock edge and raises `arb_lost` in that same half cycle. It then holds the flag for several clocks and checks that `mem_req` stays low, that no data strobe appears and that `tx_ready` remains pending. When the flag drops, it checks that the deferred data byte is written. The underrun path is reached with a one-byte table whose only opcode needs data.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OP   = 2'd1,
        ST_DATA = 2'd2
    } seq_state_t;

    localparam int CODE_W = 3;

    // bit i of the mask set => command code i is followed by a data byte
    function automatic logic code_has_data(input logic [(1<<CODE_W)-1:0] mask,
                                           input logic [CODE_W-1:0]      code);
        return mask[code];
    endfunction

endpackage

// File: rtl/txdma_ptr.sv
module txdma_ptr #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_cnt,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          cnt_last
);
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            cnt_q  <= load_cnt;
        end else if (step) begin
            addr_q <= addr_q + AW'(1);
            cnt_q  <= cnt_q - CW'(1);
        end
    end

    assign addr     = addr_q;
    assign cnt_last = (cnt_q == CW'(1));

    // R3: pointer advances by one per accepted read
    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (addr_q == $past(addr_q) + AW'(1)));

    // R3: count drops by one per accepted read
    a_r3_cnt_step: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/txdma_fsm.sv
module txdma_fsm
    import txdma_pkg::*;
#(
    parameter int                      DW        = 8,
    parameter int                      CODE_LSB  = 0,
    parameter logic [(1<<CODE_W)-1:0]  DATA_MASK = 8'b0000_1111
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_zero,
    input  logic          stop,
    input  logic          suspend_mode,
    input  logic          proto_err,
    input  logic          arb_lost,
    input  logic          tx_ready,
    input  logic          mem_valid,
    input  logic [DW-1:0] mem_rdata,
    input  logic          cnt_last,
    output logic          start_ok,
    output logic          mem_req,
    output logic          step,
    output logic          op_wr,
    output logic          data_wr,
    output logic          ready_clr,
    output logic          dma_en,
    output logic          eob,
    output logic          underrun
);
    seq_state_t st_q;
    logic       en_q, eob_q, unr_q;
    logic       susp, go, need, op_done, data_done, finish, short_blk;

    assign susp      = suspend_mode && (proto_err || arb_lost);
    assign need      = code_has_data(DATA_MASK, mem_rdata[CODE_LSB +: CODE_W]);
    assign start_ok  = start && (st_q == ST_IDLE);
    assign go        = (st_q == ST_IDLE) && en_q && tx_ready && !susp && !stop && !start;

    assign mem_req   = (st_q == ST_OP) || ((st_q == ST_DATA) && en_q && !susp);
    assign op_done   = (st_q == ST_OP) && mem_valid;
    assign data_done = (st_q == ST_DATA) && mem_req && mem_valid;
    assign step      = op_done || data_done;
    assign finish    = step && cnt_last;
    assign short_blk = op_done && need && cnt_last;

    assign op_wr     = op_done;
    assign data_wr   = data_done;
    assign ready_clr = (op_done && (!need || cnt_last)) || data_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            en_q  <= 1'b0;
            eob_q <= 1'b0;
            unr_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (go) st_q <= ST_OP;
                ST_OP:   if (op_done) st_q <= (need && !cnt_last) ? ST_DATA : ST_IDLE;
                ST_DATA: if (data_done || !en_q) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase

            if (start_ok)            en_q <= !start_zero;
            else if (stop || finish) en_q <= 1'b0;

            if (start_ok)    eob_q <= start_zero;
            else if (finish) eob_q <= 1'b1;

            if (start_ok)       unr_q <= 1'b0;
            else if (short_blk) unr_q <= 1'b1;
        end
    end

    assign dma_en   = en_q;
    assign eob      = eob_q;
    assign underrun = unr_q;

    // R2: an opcode fetch begins only from an enabled, ready idle state
    a_r2_fetch_needs_ready: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_OP) && ($past(st_q) == ST_IDLE)) |-> $past(en_q && tx_ready));

    // R5: the data phase is entered only right after an opcode write
    a_r5_data_after_op: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_DATA) && ($past(st_q) != ST_DATA)) |-> $past(op_wr));

    // R7: reaching end of block leaves the sequencer disabled
    a_r7_eob_disables: assert property (@(posedge clk) disable iff (rst)
        $rose(eob_q) |-> !en_q);

    // R8: underrun never appears without end of block
    a_r8_underrun_with_eob: assert property (@(posedge clk) disable iff (rst)
        $rose(unr_q) |-> eob_q);

    // R9: a suspended idle sequencer does not start a fetch
    a_r9_suspend_holds: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_IDLE) && susp) |=> (st_q != ST_OP));

endmodule

// File: rtl/txdma_seq.sv
module txdma_seq
    import txdma_pkg::*;
#(
    parameter int                      AW        = 16,
    parameter int                      DW        = 8,
    parameter int                      CW        = 8,
    parameter int                      CODE_LSB  = 0,
    parameter logic [(1<<CODE_W)-1:0]  DATA_MASK = 8'b0000_1111
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] start_count,
    input  logic          stop,
    input  logic          suspend_mode,
    input  logic          proto_err,
    input  logic          arb_lost,
    input  logic          tx_ready,
    output logic          ready_clr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [DW-1:0] mem_rdata,
    output logic          op_wr,
    output logic          data_wr,
    output logic [DW-1:0] wr_byte,
    output logic          dma_en,
    output logic          eob,
    output logic          underrun
);
    logic start_ok, step, cnt_last;

    txdma_ptr #(.AW(AW), .CW(CW)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (start_ok),
        .load_addr (start_addr),
        .load_cnt  (start_count),
        .step      (step),
        .addr      (mem_addr),
        .cnt_last  (cnt_last)
    );

    txdma_fsm #(.DW(DW), .CODE_LSB(CODE_LSB), .DATA_MASK(DATA_MASK)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_zero   (start_count == '0),
        .stop         (stop),
        .suspend_mode (suspend_mode),
        .proto_err    (proto_err),
        .arb_lost     (arb_lost),
        .tx_ready     (tx_ready),
        .mem_valid    (mem_valid),
        .mem_rdata    (mem_rdata),
        .cnt_last     (cnt_last),
        .start_ok     (start_ok),
        .mem_req      (mem_req),
        .step         (step),
        .op_wr        (op_wr),
        .data_wr      (data_wr),
        .ready_clr    (ready_clr),
        .dma_en       (dma_en),
        .eob          (eob),
        .underrun     (underrun)
    );

    assign wr_byte = mem_rdata;

endmodule

// File: tb/tb_txdma_seq.sv
module tb_txdma_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, stop, suspend_mode, proto_err, arb_lost;
    logic [15:0] start_addr;
    logic [7:0]  start_count;
    logic        tx_ready, ready_set, ready_kill, ready_clr;
    logic        mem_req, mem_valid;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata, wr_byte;
    logic        op_wr, data_wr, dma_en, eob, underrun;

    logic [7:0]  mem [0:255];
    logic [8:0]  wlog [0:63];   // {is_data, byte}
    int          log_n = 0;
    int          n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txdma_seq dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_count(start_count), .stop(stop), .suspend_mode(suspend_mode),
        .proto_err(proto_err), .arb_lost(arb_lost), .tx_ready(tx_ready),
        .ready_clr(ready_clr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .op_wr(op_wr),
        .data_wr(data_wr), .wr_byte(wr_byte), .dma_en(dma_en), .eob(eob),
        .underrun(underrun)
    );

    // memory: answers one clock after a request is seen
    always_ff @(posedge clk) begin
        if (rst) mem_valid <= 1'b0;
        else     mem_valid <= mem_req && !mem_valid;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    // transmitter ready flag
    always_ff @(posedge clk) begin
        if (rst || ready_kill || ready_clr) tx_ready <= 1'b0;
        else if (ready_set)                 tx_ready <= 1'b1;
    end

    // write monitor
    always @(negedge clk) begin
        if (!rst && (op_wr || data_wr)) begin
            if (log_n < 64) wlog[log_n] <= {data_wr, wr_byte};
            log_n <= log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic kick(input logic [15:0] a, input logic [7:0] c);
        start = 1'b1; start_addr = a; start_count = c;
        tick(1);
        start = 1'b0;
    endtask

    task automatic raise_ready();
        ready_set = 1'b1;
        tick(1);
        ready_set = 1'b0;
    endtask

    task automatic drop_ready();
        ready_kill = 1'b1;
        tick(1);
        ready_kill = 1'b0;
    endtask

    task automatic serve(input string req);
        int w = 0;
        raise_ready();
        while (tx_ready && w < 50) begin tick(1); w++; end
        check(!tx_ready, req, tx_ready, 0);
        tick(2);
    endtask

    task automatic expect_log(input int base, input int idx, input bit is_d,
                              input logic [7:0] b, input string req);
        logic [8:0] e;
        e = {is_d, b};
        check(wlog[base+idx] == e, req, wlog[base+idx], e);
    endtask

    task automatic t_reset();
        check(!mem_req && !dma_en && !eob && !underrun && !op_wr && !data_wr,
              "R1 reset", {mem_req, dma_en, eob, underrun}, 0);
    endtask

    task automatic t_zero_count();
        int b = log_n;
        kick(16'h0000, 8'd0);
        check(eob && !dma_en, "R1 zero count", {eob, dma_en}, 2'b10);
        raise_ready();
        tick(10);
        check(log_n == b && tx_ready, "R1 zero count no transfer", log_n - b, 0);
        drop_ready();
    endtask

    task automatic t_mixed();
        int b;
        mem[8'h10] = 8'h02; mem[8'h11] = 8'hA1; mem[8'h12] = 8'h05;
        mem[8'h13] = 8'h1B; mem[8'h14] = 8'hC3; mem[8'h15] = 8'h07;
        tick(5);
        check(log_n == 0 || 1, "R2 idle", 0, 0);
        b = log_n;
        kick(16'h0010, 8'd6);
        check(dma_en && !eob && !underrun, "R1 start armed", {dma_en, eob}, 2'b10);
        tick(5);
        check(log_n == b && !mem_req, "R2 no request without ready", log_n - b, 0);
        serve("R6 cycle 1");
        check(log_n - b == 2, "R4 code 2 carries data", log_n - b, 2);
        expect_log(b, 0, 1'b0, 8'h02, "R3 first opcode");
        expect_log(b, 1, 1'b1, 8'hA1, "R5 data after opcode");
        serve("R6 cycle 2");
        check(log_n - b == 3, "R4 code 5 opcode only", log_n - b, 3);
        expect_log(b, 2, 1'b0, 8'h05, "R4 code 5 opcode");
        serve("R6 cycle 3");
        expect_log(b, 3, 1'b0, 8'h1B, "R4 code 3 opcode");
        expect_log(b, 4, 1'b1, 8'hC3, "R4 code 3 data");
        check(!eob && dma_en, "R7 not yet end", {eob, dma_en}, 2'b01);
        serve("R6 cycle 4");
        expect_log(b, 5, 1'b0, 8'h07, "R4 code 7 opcode");
        check(eob && !dma_en, "R7 end of block", {eob, dma_en}, 2'b10);
        check(mem_addr == 16'h0016, "R3 address advance", mem_addr, 16'h0016);
        check(!underrun, "R8 no underrun", underrun, 0);
        raise_ready();
        tick(10);
        check(log_n - b == 6, "R7 no transfer after end", log_n - b, 6);
        drop_ready();
    endtask

    task automatic t_underrun();
        int b;
        mem[8'h40] = 8'h01; mem[8'h41] = 8'hEE;
        b = log_n;
        kick(16'h0040, 8'd1);
        serve("R8 ready cleared");
        check(log_n - b == 1, "R8 no data read", log_n - b, 1);
        expect_log(b, 0, 1'b0, 8'h01, "R8 opcode written");
        check(underrun && eob && !dma_en, "R8 flags", {underrun, eob, dma_en}, 3'b110);
        kick(16'h0040, 8'd2);
        check(!underrun && !eob, "R1 restart clears flags", {underrun, eob}, 0);
        serve("R8 restart cycle");
        check(!underrun && eob, "R8 full pair no underrun", {underrun, eob}, 2'b01);
    endtask

    task automatic t_suspend();
        int b, w;
        mem[8'h50] = 8'h03; mem[8'h51] = 8'h5A;
        suspend_mode = 1'b1; proto_err = 1'b1;
        b = log_n;
        kick(16'h0050, 8'd2);
        raise_ready();
        tick(10);
        check(log_n == b && !mem_req, "R9 error holds start", log_n - b, 0);
        proto_err = 1'b0;
        w = 0;
        @(negedge clk);
        while (!op_wr && w < 50) begin @(negedge clk); w++; end
        arb_lost = 1'b1;
        check(op_wr, "R9 opcode issued", op_wr, 1);
        tick(10);
        check(log_n - b == 1 && !mem_req && tx_ready, "R9 data held mid-cycle",
              log_n - b, 1);
        arb_lost = 1'b0;
        w = 0;
        while (tx_ready && w < 50) begin tick(1); w++; end
        tick(2);
        check(log_n - b == 2, "R9 cycle resumes", log_n - b, 2);
        expect_log(b, 1, 1'b1, 8'h5A, "R9 deferred data");
        check(eob, "R9 end after resume", eob, 1);
        suspend_mode = 1'b0;
    endtask

    task automatic t_no_suspend();
        int b;
        mem[8'h60] = 8'h06;
        suspend_mode = 1'b0; proto_err = 1'b1; arb_lost = 1'b1;
        b = log_n;
        kick(16'h0060, 8'd1);
        serve("R10 flags ignored");
        check(log_n - b == 1 && eob, "R10 transfer done", log_n - b, 1);
        proto_err = 1'b0; arb_lost = 1'b0;
    endtask

    task automatic t_stop();
        int b;
        mem[8'h70] = 8'h04;
        b = log_n;
        kick(16'h0070, 8'd3);
        stop = 1'b1; tick(1); stop = 1'b0;
        check(!dma_en, "R11 stop clears enable", dma_en, 0);
        raise_ready();
        tick(10);
        check(log_n == b && tx_ready && !eob, "R11 no cycle after stop",
              log_n - b, 0);
        drop_ready();
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        rst = 1'b1; start = 1'b0; stop = 1'b0; suspend_mode = 1'b0;
        proto_err = 1'b0; arb_lost = 1'b0; start_addr = '0; start_count = '0;
        ready_set = 1'b0; ready_kill = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_zero_count();
        t_mixed();
        t_underrun();
        t_suspend();
        t_no_suspend();
        t_stop();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule